// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 operands and records the outcome as a two-bit condition code inside a floating-point status word. Both operands share one format. A precision select chooses between single precision, which uses the low 32 bits of each operand bus, and double precision, which uses all 64 bits. The status word holds four condition fields, and a field index chooses which of them receives the code. Every other bit of the word passes through unchanged.

A caller drives the operands, the precision, the field index and the current status word, then pulses `start_i` for one cycle. On the following cycle `done_o` is high and `status_o` holds the updated word. Each status bit lands in the field of its own index. If either operand is a NaN, the result is unordered. An unordered result also raises `trap_o` when the invalid-operation trap mask bit of the incoming status word is set.

Top module: `fp_cond_cmp`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `status_o`, `done_o` and `trap_o` are all zero.
- R2: `done_o` is high in exactly the cycle after each cycle in which `start_i` is high, and low in every other cycle.
- R3: The code is 0 for equal, 1 for operand A less than operand B, 2 for A greater than B and 3 for unordered. For field index k it is written to `status_o` bits [9+2k:8+2k], with the low code bit at bit 8+2k.
- R4: After a compare, every `status_o` bit outside the selected field equals the `status_i` bit that was sampled with `start_i`. The selected field is cleared before the code is written, so old field contents never survive.
- R5: A NaN in either operand gives code 3. A NaN has an all-ones exponent and a nonzero fraction. Quiet and signalling NaNs are treated alike.
- R6: An unordered compare with `status_i` bit 23 (the invalid-operation trap mask) set raises `trap_o` for the same single cycle as `done_o`. The code 3 is still written.
- R7: `trap_o` stays low for an ordered result, and also for an unordered result when the mask bit 23 is clear.
- R8: Positive zero and negative zero compare equal in both precisions.
- R9: Ordering follows signed values, including negative operands, mixed signs, infinities and subnormals.
- R10: With `dbl_i` = 0, only bits [31:0] of each operand are used and bits [63:32] have no effect. With `dbl_i` = 1, all 64 bits are used.
- R11: In cycles that follow a cycle without `start_i`, `status_o` keeps its previous value whatever `status_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a compare of the current inputs |
| dbl_i | input | 1 | 0 selects single precision, 1 selects double precision |
| field_i | input | 2 | Index of the condition field to write (0 to 3) |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| status_i | input | 32 | Current status word, including the trap mask at bit 23 |
| status_o | output | 32 | Updated status word |
| done_o | output | 1 | One-cycle completion strobe |
| trap_o | output | 1 | Invalid-operation trap request |

## Verification
Two things can happen in the same cycle: the unordered code is written into the status word, and the trap request is raised. The bench provokes this with NaN operands while the mask bit is set. It checks, in the cycle where `done_o` is high, that `trap_o` is high and that the selected field reads 3 with its neighbours untouched. Back-to-back starts put a new field write on the cycle right after the previous one. A behavioural model judges every cycle. The model converts the operands to real numbers and compares them as values, and it is checked for done, trap and the full status word.

// File: rtl/fp_cond_cmp_pkg.sv
package fp_cond_cmp_pkg;

    localparam int unsigned SGL_EXP_W = 8;
    localparam int unsigned SGL_MAN_W = 23;
    localparam int unsigned DBL_EXP_W = 11;
    localparam int unsigned DBL_MAN_W = 52;
    localparam int unsigned OPND_W    = 1 + DBL_EXP_W + DBL_MAN_W;
    localparam int unsigned MAG_W     = OPND_W - 1;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } opnd_info_t;

endpackage

// File: rtl/fp_cond_classify.sv
module fp_cond_classify
    import fp_cond_cmp_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word_i,
    output opnd_info_t           info_o
);
    localparam int unsigned TOP = EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_d;
    logic [MAN_W-1:0] man_d;

    always_comb begin
        exp_d          = word_i[TOP-1:MAN_W];
        man_d          = word_i[MAN_W-1:0];
        info_o.sign    = word_i[TOP];
        info_o.is_nan  = (&exp_d) && (|man_d);
        info_o.is_zero = ~(|exp_d) && ~(|man_d);
        info_o.mag     = MAG_W'(word_i[TOP-1:0]);
    end

endmodule

// File: rtl/fp_cond_order.sv
module fp_cond_order
    import fp_cond_cmp_pkg::*;
(
    input  opnd_info_t a_i,
    input  opnd_info_t b_i,
    output cc_e        code_o
);
    logic mag_lt_d;
    logic mag_eq_d;

    always_comb begin
        mag_lt_d = a_i.mag < b_i.mag;
        mag_eq_d = a_i.mag == b_i.mag;
        if (a_i.is_nan || b_i.is_nan) begin
            code_o = CC_UN;
        end else if (a_i.is_zero && b_i.is_zero) begin
            code_o = CC_EQ;
        end else if (a_i.sign != b_i.sign) begin
            code_o = a_i.sign ? CC_LT : CC_GT;
        end else if (mag_eq_d) begin
            code_o = CC_EQ;
        end else begin
            code_o = (mag_lt_d ^ a_i.sign) ? CC_LT : CC_GT;
        end
    end

endmodule

// File: rtl/fp_cond_cmp.sv
module fp_cond_cmp
    import fp_cond_cmp_pkg::*;
#(
    parameter int unsigned SR_W       = 32,
    parameter int unsigned NUM_FIELDS = 4,
    parameter int unsigned FIELD_LSB  = 8,
    parameter int unsigned TRAP_BIT   = 23,
    localparam int unsigned IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dbl_i,
    input  logic [IDX_W-1:0]  field_i,
    input  logic [OPND_W-1:0] op_a_i,
    input  logic [OPND_W-1:0] op_b_i,
    input  logic [SR_W-1:0]   status_i,
    output logic [SR_W-1:0]   status_o,
    output logic              done_o,
    output logic              trap_o
);
    localparam int unsigned SGL_W = 1 + SGL_EXP_W + SGL_MAN_W;

    typedef struct packed {
        logic [SR_W-1:0] status;
        logic            done;
        logic            trap;
    } state_t;

    state_t state_d, state_q;

    logic [OPND_W-1:0] opnd_d [2];
    opnd_info_t        sgl_info_d [2];
    opnd_info_t        dbl_info_d [2];
    opnd_info_t        sel_info_d [2];
    cc_e               code_d;
    logic [SR_W-1:0]   sel_mask_d;
    int unsigned       sel_pos_d;

    assign opnd_d[0] = op_a_i;
    assign opnd_d[1] = op_b_i;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        fp_cond_classify #(
            .EXP_W (SGL_EXP_W),
            .MAN_W (SGL_MAN_W)
        ) u_sgl (
            .word_i (opnd_d[g][SGL_W-1:0]),
            .info_o (sgl_info_d[g])
        );

        fp_cond_classify #(
            .EXP_W (DBL_EXP_W),
            .MAN_W (DBL_MAN_W)
        ) u_dbl (
            .word_i (opnd_d[g]),
            .info_o (dbl_info_d[g])
        );

        assign sel_info_d[g] = dbl_i ? dbl_info_d[g] : sgl_info_d[g];
    end

    fp_cond_order u_order (
        .a_i    (sel_info_d[0]),
        .b_i    (sel_info_d[1]),
        .code_o (code_d)
    );

    always_comb begin
        sel_pos_d  = FIELD_LSB + 2 * int'(field_i);
        sel_mask_d = SR_W'(2'b11) << sel_pos_d;
        state_d    = state_q;
        state_d.done = start_i;
        state_d.trap = start_i && (code_d == CC_UN) && status_i[TRAP_BIT];
        if (start_i) begin
            state_d.status = (status_i & ~sel_mask_d)
                           | (SR_W'(code_d) << sel_pos_d);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;
    assign done_o   = state_q.done;
    assign trap_o   = state_q.trap;

    function automatic logic [1:0] code_at(input logic [SR_W-1:0] sr,
                                           input logic [IDX_W-1:0] idx);
        return 2'(sr >> (FIELD_LSB + 2 * int'(idx)));
    endfunction

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o); // R2
    AST_NEIGHBOUR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (((status_o ^ $past(status_i)) & ~$past(sel_mask_d)) == '0)); // R4
    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (sel_info_d[0].is_nan || sel_info_d[1].is_nan)
        |=> code_at(status_o, $past(field_i)) == 2'd3); // R5
    AST_TRAP_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && status_i[TRAP_BIT] && (sel_info_d[0].is_nan || sel_info_d[1].is_nan)
        |=> trap_o && done_o); // R6
    AST_TRAP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !status_i[TRAP_BIT] |=> !trap_o); // R7
    AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> done_o); // R7
    AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && sel_info_d[0].is_zero && sel_info_d[1].is_zero
        |=> code_at(status_o, $past(field_i)) == 2'd0); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(status_o)); // R11

endmodule

// File: tb/fp_cond_cmp_tb.sv
module fp_cond_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        dbl_i;
    logic [1:0]  field_i;
    logic [63:0] op_a_i;
    logic [63:0] op_b_i;
    logic [31:0] status_i;
    logic [31:0] status_o;
    logic        done_o;
    logic        trap_o;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    string m_tag   = "R1";

    logic [31:0] m_status;
    logic        m_done;
    logic        m_trap;

    always #2.5 clk = ~clk;

    fp_cond_cmp u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .dbl_i    (dbl_i),
        .field_i  (field_i),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .status_i (status_i),
        .status_o (status_o),
        .done_o   (done_o),
        .trap_o   (trap_o)
    );

    // single precision bits to double precision bits, value-preserving
    function automatic logic [63:0] widen(input logic [31:0] f);
        logic        s = f[31];
        int          e = int'(f[30:23]);
        logic [23:0] m = {1'b0, f[22:0]};
        if (e == 255) return {s, 11'h7FF, m[22:0], 29'b0};
        if (e == 0 && m == 0) return {s, 63'b0};
        if (e == 0) begin
            e = 1;
            while (!m[23]) begin
                m = m << 1;
                e = e - 1;
            end
        end
        return {s, 11'(e - 127 + 1023), m[22:0], 29'b0};
    endfunction

    function automatic logic [1:0] ref_code(input logic [63:0] a, input logic [63:0] b,
                                            input logic dbl);
        logic [63:0] da = dbl ? a : widen(a[31:0]);
        logic [63:0] db = dbl ? b : widen(b[31:0]);
        real ra, rb;
        if ((da[62:52] == 11'h7FF && da[51:0] != 0) ||
            (db[62:52] == 11'h7FF && db[51:0] != 0)) return 2'd3;
        ra = $bitstoreal(da);
        rb = $bitstoreal(db);
        if (ra < rb) return 2'd1;
        if (ra > rb) return 2'd2;
        return 2'd0;
    endfunction

    // behavioural reference, updated every clock
    always @(posedge clk) begin
        logic [1:0] c;
        c = ref_code(op_a_i, op_b_i, dbl_i);
        m_tag <= cur_tag;
        if (!rst_n) begin
            m_status <= '0;
            m_done   <= 1'b0;
            m_trap   <= 1'b0;
        end else begin
            m_done <= start_i;
            m_trap <= start_i && c == 2'd3 && status_i[23];
            if (start_i) begin
                m_status <= status_i;
                m_status[8 + 2*field_i +: 2] <= c;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        #1;
        check(m_tag, "done", 32'(done_o), 32'(m_done));
        check(m_tag, "trap", 32'(trap_o), 32'(m_trap));
        check(m_tag, "status", status_o, m_status);
    end

    task automatic cmp(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic dbl, input logic [1:0] fld, input logic [31:0] sr);
        @(negedge clk);
        cur_tag  = tag;
        start_i  = 1'b1;
        op_a_i   = a;
        op_b_i   = b;
        dbl_i    = dbl;
        field_i  = fld;
        status_i = sr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i  = 1'b0;
            status_i = status_i ^ 32'h5A5A_A5A5;
            cur_tag  = "R11";
        end
    endtask

    // directed expectation of one field, sampled in the done cycle
    task automatic expect_field(input string tag, input logic [1:0] fld,
                                input logic [1:0] code, input logic trap);
        @(posedge clk);
        #1;
        check(tag, "field", 32'(status_o[8 + 2*fld +: 2]), 32'(code));
        check(tag, "done_strobe", 32'(done_o), 32'd1);
        check(tag, "trap_req", 32'(trap_o), 32'(trap));
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0; start_i = 1'b0; dbl_i = 1'b0; field_i = 2'd0;
        op_a_i = '0; op_b_i = '0; status_i = '1;
        repeat (3) @(negedge clk);
        check("R1", "reset_status", status_o, 32'd0);
        check("R1", "reset_done", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R3 each code into each field
        cmp("R3", 64'h3F800000, 64'h40000000, 1'b0, 2'd0, 32'h0);
        expect_field("R3", 2'd0, 2'd1, 1'b0);
        idle(1);
        cmp("R3", 64'h40000000, 64'h3F800000, 1'b0, 2'd1, 32'h0);
        expect_field("R3", 2'd1, 2'd2, 1'b0);
        idle(1);
        cmp("R4", 64'h40000000, 64'h40000000, 1'b0, 2'd2, 32'hFFFF_FFFF);
        expect_field("R4", 2'd2, 2'd0, 1'b0);
        idle(1);
        cmp("R3", 64'h40000000, 64'h3F800000, 1'b0, 2'd3, 32'h1234_0000);
        expect_field("R3", 2'd3, 2'd2, 1'b0);
        // R8 signed zeros
        cmp("R8", 64'h80000000, 64'h00000000, 1'b0, 2'd0, 32'h0000_0300);
        expect_field("R8", 2'd0, 2'd0, 1'b0);
        cmp("R8", 64'h8000_0000_0000_0000, 64'h0, 1'b1, 2'd1, 32'h0);
        expect_field("R8", 2'd1, 2'd0, 1'b0);
        // R9 signed ordering
        cmp("R9", 64'hBF800000, 64'hC0000000, 1'b0, 2'd0, 32'h0);
        expect_field("R9", 2'd0, 2'd2, 1'b0);
        cmp("R9", 64'hBF800000, 64'h3F800000, 1'b0, 2'd1, 32'h0);
        expect_field("R9", 2'd1, 2'd1, 1'b0);
        cmp("R9", 64'h7F800000, 64'h7F7FFFFF, 1'b0, 2'd2, 32'h0);
        expect_field("R9", 2'd2, 2'd2, 1'b0);
        cmp("R9", 64'h80000001, 64'h00000000, 1'b0, 2'd3, 32'h0);
        expect_field("R9", 2'd3, 2'd1, 1'b0);
        // R5 / R7 NaN without trap, R6 NaN with trap
        cmp("R5", 64'h7FC00000, 64'h3F800000, 1'b0, 2'd0, 32'h0);
        expect_field("R5", 2'd0, 2'd3, 1'b0);
        cmp("R6", 64'h3F800000, 64'h7F800001, 1'b0, 2'd2, 32'h0080_0000);
        expect_field("R6", 2'd2, 2'd3, 1'b1);
        cmp("R6", 64'h7FF0_0000_0000_0001, 64'h0, 1'b1, 2'd1, 32'h0080_0F00);
        expect_field("R6", 2'd1, 2'd3, 1'b1);
        cmp("R7", 64'h3F800000, 64'h40000000, 1'b0, 2'd1, 32'h0080_0000);
        expect_field("R7", 2'd1, 2'd1, 1'b0);
        // R10 precision select
        cmp("R10", 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 1'b0, 2'd0, 32'h0);
        expect_field("R10", 2'd0, 2'd1, 1'b0);
        cmp("R10", 64'h3FF8_0000_0000_0000, 64'h3FF4_0000_0000_0000, 1'b1, 2'd3, 32'h0);
        expect_field("R10", 2'd3, 2'd2, 1'b0);
        cmp("R10", 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b1, 2'd0, 32'h0);
        expect_field("R10", 2'd0, 2'd2, 1'b0);
        // R11 idle holds status while status_i toggles
        idle(4);
        // R2 back-to-back random compares, including specials
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            a = {lfsr, lfsr ^ 32'h9E37_79B9};
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            b = (lfsr[3:0] == 0) ? a : {lfsr ^ 32'h7F00_0000, lfsr};
            if (lfsr[7:5] == 3'd1) a[30:23] = 8'hFF;
            if (lfsr[7:5] == 3'd2) b[62:52] = 11'h7FF;
            cmp("R2", a, b, lfsr[9], lfsr[11:10], lfsr ^ {lfsr[15:0], lfsr[31:16]});
            if (lfsr[13:12] == 2'd0) idle(1);
        end
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule